// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

This block collects four peripheral event pulses: timer 1 overflow, timer 2 overflow, a waveform generator event and a compare channel 5 event. It merges them into two summary interrupt flags. Each event is recorded in a source pending register, whether or not it is masked. A read of that register returns its contents and clears it, so software reads it once into a shadow copy and then tests that copy. A source mask register controls which events may raise a summary flag. The two timer overflows feed the TOVF summary flag. The waveform generator and compare 5 events feed the PI summary flag.

The summary flags sit in a main pending register, and a main mask register sits beside it. An interrupt request is raised only while a summary flag is set and its main mask bit is set. A summary flag can be raised only by an event whose source mask bit was set. An interrupt therefore needs both mask levels. A summary flag is cleared when software writes 0 to its bit, or when an acknowledge input pulses as the interrupt is taken.

Each summary flag is a two-state machine. `SUM_CLEAR` moves to `SUM_RAISED` on a qualified event. `SUM_RAISED` returns to `SUM_CLEAR` on an acknowledge or a software write of 0, but only if no qualified event arrives in the same cycle. Register access uses a simple synchronous bus. Read data is combinational from the address. A read strobe at the source pending address clears that register at the next clock edge.

Top module: `pi_irq_aggregator`

## Requirements
- R1: After reset, the main mask and main pending registers read 0x00, the source mask and source pending registers read 0xAA, and both interrupt requests are low.
- R2: The source mask register (address 2) keeps written values only in bits 0, 2, 4 and 6. Bits 1, 3, 5 and 7 always read as 1, whatever value was written to them.
- R3: A one-cycle pulse on `evt_in[i]` sets source pending bit 2*i at the next clock edge, whether or not the source is masked. The bit mapping is: timer 1 to bit 0, timer 2 to bit 2, waveform generator to bit 4, compare 5 to bit 6. Address 3 is read-only, and its reserved bits read as 1.
- R4: A read strobe at address 3 returns the current contents and clears all of its bits at that clock edge.
- R5: If an event arrives in the same cycle as a read-clear, the event's pending bit is still set after the read.
- R6: The PI flag (main pending bit 5) sets at the next edge only when a waveform generator or compare 5 event arrives while that event's source mask bit is set.
- R7: The TOVF flag (main pending bit 0) sets at the next edge only when a timer 1 or timer 2 overflow arrives while that event's source mask bit is set.
- R8: `irq_pi` equals the PI flag ANDed with main mask bit 5. `irq_tovf` equals the TOVF flag ANDed with main mask bit 0.
- R9: A write to the main pending register (address 1) clears each summary flag whose data bit is 0. A data bit of 1 leaves that flag unchanged and never sets it.
- R10: `ack_pi` clears the PI flag and `ack_tovf` clears the TOVF flag. A qualified event in the same cycle wins over the clear.
- R11: The main mask register (address 0) stores bits 5 and 0. All its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address (0 main mask, 1 main pending, 2 source mask, 3 source pending) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; at address 3 it clears the source pending register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| evt_in | input | 4 | Event pulses: [0] timer 1 overflow, [1] timer 2 overflow, [2] waveform generator, [3] compare 5 |
| ack_pi | input | 1 | Acknowledge, clears the PI flag |
| ack_tovf | input | 1 | Acknowledge, clears the TOVF flag |
| irq_pi | output | 1 | PI interrupt request |
| irq_tovf | output | 1 | TOVF interrupt request |

## Verification
The main sweep covers all 16 source mask patterns. For each pattern, it fires each of the four events on its own, under a rotating main mask pattern. This separates the source-to-bit mapping, the routing of each source to the PI or TOVF flag, and the gating at both mask levels. Each single-source shot is followed by a second pending read. That read shows the clear-on-read, and it shows that the two flags remain independent. Targeted sequences then cover the collisions that the sweep cannot reach: an event arriving during a read-clear, an event arriving during an acknowledge, and writes of 1 versus 0 to the summary flags.

// File: rtl/pi_pkg.sv
package pi_pkg;
    localparam int ADR_MAIN_MASK = 0;
    localparam int ADR_MAIN_PEND = 1;
    localparam int ADR_SRC_MASK  = 2;
    localparam int ADR_SRC_PEND  = 3;

    localparam int PI_BIT   = 5;
    localparam int TOVF_BIT = 0;

    localparam int SRC_T1 = 0;
    localparam int SRC_T2 = 1;
    localparam int SRC_WG = 2;
    localparam int SRC_C5 = 3;

    typedef enum logic {
        SUM_CLEAR  = 1'b0,
        SUM_RAISED = 1'b1
    } sum_state_t;
endpackage

// File: rtl/pi_src_latch.sv
module pi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (evt)
            pend <= 1'b1;
        else if (rd_clr)
            pend <= 1'b0;
    end

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);
    assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && rd_clr) |=> pend);
    assert_rdclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !evt) |=> !pend);
endmodule

// File: rtl/pi_sum_flag.sv
module pi_sum_flag
    import pi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    sum_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_CLEAR:  if (set_i) state_d = SUM_RAISED;
            SUM_RAISED: if (clr_i && !set_i) state_d = SUM_CLEAR;
            default:    state_d = SUM_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SUM_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == SUM_RAISED);
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> (flag == $past(flag)));
endmodule

// File: rtl/pi_irq_aggregator.sv
module pi_irq_aggregator
    import pi_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int N_SRC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [2*N_SRC-1:0]   wr_data,
    output logic [2*N_SRC-1:0]   rd_data,
    input  logic [N_SRC-1:0]     evt_in,
    input  logic                 ack_pi,
    input  logic                 ack_tovf,
    output logic                 irq_pi,
    output logic                 irq_tovf
);
    localparam int DATA_W = 2 * N_SRC;

    logic [N_SRC-1:0] src_mask_q;
    logic [N_SRC-1:0] src_pend;
    logic             mmask_pi_q, mmask_tovf_q;
    logic             flag_pi, flag_tovf;
    logic             sel_mmask, sel_mpend, sel_smask, sel_spend;
    logic             spend_clr;
    logic             set_pi, set_tovf, clr_pi, clr_tovf;
    logic [N_SRC-1:0] qual_evt;
    logic             unused_wr_bits;

    function automatic logic [DATA_W-1:0] spread(input logic [N_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < N_SRC; i++) begin
            r[2*i]   = v[i];
            r[2*i+1] = 1'b1;
        end
        return r;
    endfunction

    assign sel_mmask = (addr == ADDR_W'(ADR_MAIN_MASK));
    assign sel_mpend = (addr == ADDR_W'(ADR_MAIN_PEND));
    assign sel_smask = (addr == ADDR_W'(ADR_SRC_MASK));
    assign sel_spend = (addr == ADDR_W'(ADR_SRC_PEND));
    assign spend_clr = rd_en && sel_spend;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mask_q   <= '0;
            mmask_pi_q   <= 1'b0;
            mmask_tovf_q <= 1'b0;
        end else if (wr_en) begin
            if (sel_smask) begin
                for (int i = 0; i < N_SRC; i++)
                    src_mask_q[i] <= wr_data[2*i];
            end
            if (sel_mmask) begin
                mmask_pi_q   <= wr_data[PI_BIT];
                mmask_tovf_q <= wr_data[TOVF_BIT];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            pi_src_latch u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (evt_in[g]),
                .rd_clr (spend_clr),
                .pend   (src_pend[g])
            );
        end
    endgenerate

    assign qual_evt = evt_in & src_mask_q;
    assign set_pi   = qual_evt[SRC_WG] | qual_evt[SRC_C5];
    assign set_tovf = qual_evt[SRC_T1] | qual_evt[SRC_T2];
    assign clr_pi   = ack_pi   | (wr_en && sel_mpend && !wr_data[PI_BIT]);
    assign clr_tovf = ack_tovf | (wr_en && sel_mpend && !wr_data[TOVF_BIT]);

    pi_sum_flag u_flag_pi (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_pi),
        .clr_i (clr_pi),
        .flag  (flag_pi)
    );

    pi_sum_flag u_flag_tovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_tovf),
        .clr_i (clr_tovf),
        .flag  (flag_tovf)
    );

    always_comb begin
        rd_data = '0;
        if (sel_mmask) begin
            rd_data[PI_BIT]   = mmask_pi_q;
            rd_data[TOVF_BIT] = mmask_tovf_q;
        end else if (sel_mpend) begin
            rd_data[PI_BIT]   = flag_pi;
            rd_data[TOVF_BIT] = flag_tovf;
        end else if (sel_smask) begin
            rd_data = spread(src_mask_q);
        end else begin
            rd_data = spread(src_pend);
        end
    end

    assign irq_pi   = flag_pi   & mmask_pi_q;
    assign irq_tovf = flag_tovf & mmask_tovf_q;

    assert_rsv_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_smask || sel_spend) |-> (rd_data[1] && rd_data[3] && rd_data[5] && rd_data[7]));
    assert_pi_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_pi && !(evt_in[SRC_WG] && src_mask_q[SRC_WG]) && !(evt_in[SRC_C5] && src_mask_q[SRC_C5])) |=> !flag_pi);
    assert_tovf_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_tovf && !(evt_in[SRC_T1] && src_mask_q[SRC_T1]) && !(evt_in[SRC_T2] && src_mask_q[SRC_T2])) |=> !flag_tovf);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pi |-> (flag_pi && mmask_pi_q)) and (irq_tovf |-> (flag_tovf && mmask_tovf_q)));
endmodule

// File: tb/test_pi_irq_aggregator.sv
module test_pi_irq_aggregator;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [3:0] evt_in;
    logic       ack_pi, ack_tovf;
    logic       irq_pi, irq_tovf;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pi_irq_aggregator i_pi_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in),
        .ack_pi(ack_pi), .ack_tovf(ack_tovf), .irq_pi(irq_pi), .irq_tovf(irq_tovf)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt_in = e;
        @(posedge clk);
        @(negedge clk);
        evt_in = '0;
    endtask

    function automatic logic [7:0] spread(input logic [3:0] v);
        logic [7:0] r = 8'hAA;
        for (int i = 0; i < 4; i++) r[2*i] = v[i];
        return r;
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wr_data = '0;
        evt_in = '0; ack_pi = 0; ack_tovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd(2'd0, d); check("R1 main mask", d, 8'h00);
        rd(2'd1, d); check("R1 main pend", d, 8'h00);
        rd(2'd2, d); check("R1 src mask", d, 8'hAA);
        rd(2'd3, d); check("R1 src pend", d, 8'hAA);
        check("R1 irqs", {6'd0, irq_pi, irq_tovf}, 8'h00);

        // R11 main mask bits
        wr(2'd0, 8'hFF); rd(2'd0, d); check("R11 mask ff", d, 8'h21);
        wr(2'd0, 8'hDE); rd(2'd0, d); check("R11 mask de", d, 8'h00);

        // R2 reserved bits read 1 even when written 1 or 0
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 smask ff", d, 8'hFF);
        wr(2'd2, 8'h00); rd(2'd2, d); check("R2 smask 00", d, 8'hAA);

        // Main sweep: R3 R4 R6 R7 R8
        for (int m = 0; m < 16; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [1:0] m1;
                logic exp_pi, exp_tv;
                m1 = 2'((m + s) % 4);
                wr(2'd2, spread(4'(m)) & 8'h55);
                rd(2'd2, d); check("R2 smask sweep", d, spread(4'(m)));
                wr(2'd0, {2'b00, m1[1], 4'b0000, m1[0]});
                rd(2'd3, d);
                wr(2'd1, 8'h00);
                pulse(4'(1 << s));
                exp_pi = (s >= 2) && m[s];
                exp_tv = (s < 2) && m[s];
                check("R8 irq", {6'd0, irq_pi, irq_tovf},
                      {6'd0, exp_pi & m1[1], exp_tv & m1[0]});
                rd(2'd3, d); check("R3 src bit", d, 8'hAA | 8'(1 << (2*s)));
                rd(2'd3, d); check("R4 read clears", d, 8'hAA);
                rd(2'd1, d); check("R6 R7 flags", d, {2'b00, exp_pi, 4'b0000, exp_tv});
            end
        end

        // R5 event during read-clear
        wr(2'd2, 8'h55);
        pulse(4'b0001);
        @(negedge clk);
        addr = 2'd3; rd_en = 1'b1; evt_in = 4'b0100;
        #1 check("R5 read value", rd_data, 8'hAB);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; evt_in = '0;
        rd(2'd3, d); check("R5 event kept", d, 8'hBA);

        // R9 software clear: 1 keeps, 0 clears, 1 never sets
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hFF); rd(2'd1, d); check("R9 write1 no set", d, 8'h00);
        pulse(4'b0101);
        rd(2'd1, d); check("R9 both set", d, 8'h21);
        wr(2'd1, 8'h20); rd(2'd1, d); check("R9 clear tovf only", d, 8'h20);
        wr(2'd1, 8'hDF); rd(2'd1, d); check("R9 clear pi", d, 8'h00);

        // R10 acknowledge
        pulse(4'b1010);
        rd(2'd1, d); check("R10 both set", d, 8'h21);
        @(negedge clk) ack_pi = 1'b1;
        @(posedge clk); @(negedge clk) ack_pi = 1'b0;
        rd(2'd1, d); check("R10 ack pi", d, 8'h01);
        @(negedge clk) begin ack_tovf = 1'b1; evt_in = 4'b0010; end
        @(posedge clk); @(negedge clk) begin ack_tovf = 1'b0; evt_in = '0; end
        rd(2'd1, d); check("R10 set wins", d, 8'h01);
        @(negedge clk) ack_tovf = 1'b1;
        @(posedge clk); @(negedge clk) ack_tovf = 1'b0;
        rd(2'd1, d); check("R10 ack tovf", d, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule